// File: doc/BRIEF.md
# Fetch Target Buffer

This block predicts the next fetch address from the current fetch PC within the same fetch cycle. It holds a small direct-mapped table. Each live entry records the full address of a branch that was last seen taken, together with that branch's target. A lookup that matches the whole PC returns the stored target. Any other lookup returns the sequential address, PC plus 4. Only branches that are expected to be taken occupy entries.

When decode resolves the instruction fetched earlier, the pipeline reports several values back to the block:
- the branch address;
- whether the lookup hit;
- the next PC that fetch used;
- whether the instruction was a taken branch;
- the actual target.

The block compares the true successor with the one that was used. When they differ, it raises a same-cycle kill-and-redirect carrying the correct address. On the following clock edge it also allocates, retargets or drops the table entry. A correctly predicted taken branch costs nothing. A non-branch that missed also costs nothing. A wrong prediction discards the wrong-path fetch, so it costs at least two cycles in the surrounding pipeline.

Top module: `fetch_target_buffer`

## Requirements
- R1: After reset every lookup misses: `hit_o` is 0 and `pred_pc_o` equals `fetch_pc_i + 4`.
- R2: A lookup hits only when the stored branch address equals `fetch_pc_i` in all bits. An address that shares the index (bits [5:2] with 16 entries) but differs in other bits misses.
- R3: On a hit, `pred_pc_o` equals the stored target in the same cycle as `fetch_pc_i` is presented.
- R4: A valid resolution with `res_hit_i`=0 and `res_taken_i`=1 raises `redirect_o` that cycle with `redirect_pc_o`=`res_target_i`. From the next clock edge, a lookup of `res_pc_i` hits with that target.
- R5: A valid resolution with `res_hit_i`=1 and `res_taken_i`=0 raises `redirect_o` with `redirect_pc_o`=`res_pc_i + 4`. From the next edge, a lookup of `res_pc_i` misses.
- R6: A valid resolution with `res_hit_i`=1, `res_taken_i`=1 and `res_pred_pc_i`=`res_target_i` gives no redirect and leaves the entry unchanged.
- R7: A valid resolution with `res_hit_i`=0, `res_taken_i`=0 and `res_pred_pc_i`=`res_pc_i + 4` gives no redirect and allocates nothing.
- R8: A valid resolution with `res_hit_i`=1 and `res_taken_i`=1 whose target differs from `res_pred_pc_i` redirects to `res_target_i`. It also rewrites the entry's target from the next edge.
- R9: While `res_valid_i` is 0, `redirect_o` is 0 and the table does not change.
- R10: Allocation into an index that holds another branch replaces it. The old branch then misses and the new one hits.
- R11: A not-taken resolution deletes the entry only if that entry still holds `res_pc_i`. A different branch that replaced it stays live, although the redirect is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | PC_W | Current fetch address |
| hit_o | output | 1 | Lookup matched a live entry |
| pred_pc_o | output | PC_W | Predicted next fetch address |
| res_valid_i | input | 1 | Resolution from decode is present |
| res_pc_i | input | PC_W | Address of the resolved instruction |
| res_hit_i | input | 1 | The lookup for that instruction hit |
| res_pred_pc_i | input | PC_W | Next PC that fetch used after it |
| res_taken_i | input | 1 | Instruction is a taken branch |
| res_target_i | input | PC_W | Actual branch target |
| redirect_o | output | 1 | Kill wrong-path fetch and restart |
| redirect_pc_o | output | PC_W | Restart address |

## Verification
The hardest case to reach is a stale deletion. A not-taken resolution reports a hit for a branch whose entry has already been overwritten by an aliasing branch. The stimulus first allocates one branch, then allocates a second branch at the same index with different upper address bits. Only after that does it resolve the first branch as not taken with its hit flag still set. The bench then confirms that the redirect fires and that the second branch keeps hitting. The bench also fills every index and reads all of them back, which exercises every valid bit and every stored target.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_DROP  = 2'd2
  } ftb_act_e;

  localparam int unsigned INSTR_BYTES = 4;
endpackage

// File: rtl/ftb_store.sv
module ftb_store
  import ftb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  // fetch read port
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic             rd_a_vld_o,
  output logic [PC_W-1:0]  rd_a_pc_o,
  output logic [PC_W-1:0]  rd_a_tgt_o,
  // resolve read port
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic             rd_b_vld_o,
  output logic [PC_W-1:0]  rd_b_pc_o,
  // update port
  input  ftb_act_e         act_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PC_W-1:0]  wr_pc_i,
  input  logic [PC_W-1:0]  wr_tgt_i
);
  logic [ENTRIES-1:0] vld_q;
  logic [PC_W-1:0]    pc_q  [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
      end else if (sel && act_i == ACT_WRITE) begin
        vld_q[g] <= 1'b1;
      end else if (sel && act_i == ACT_DROP) begin
        vld_q[g] <= 1'b0;
      end
    end

    // payload needs no reset; guarded by valid
    always_ff @(posedge clk_i) begin
      if (sel && act_i == ACT_WRITE) begin
        pc_q[g]  <= wr_pc_i;
        tgt_q[g] <= wr_tgt_i;
      end
    end
  end

  assign rd_a_vld_o  = vld_q[rd_a_idx_i];
  assign rd_a_pc_o   = pc_q[rd_a_idx_i];
  assign rd_a_tgt_o  = tgt_q[rd_a_idx_i];
  assign rd_b_vld_o  = vld_q[rd_b_idx_i];
  assign rd_b_pc_o   = pc_q[rd_b_idx_i];

  // R4
  write_sets_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_WRITE |=> vld_q[$past(wr_idx_i)]);

  // R5
  drop_clears_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_DROP |=> !vld_q[$past(wr_idx_i)]);

  // R9
  idle_keeps_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_NONE |=> $stable(vld_q));
endmodule

// File: rtl/ftb_resolve.sv
module ftb_resolve
  import ftb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned LSB    = $clog2(INSTR_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_valid_i,
  input  logic [PC_W-1:0]  res_pc_i,
  input  logic             res_hit_i,
  input  logic [PC_W-1:0]  res_pred_pc_i,
  input  logic             res_taken_i,
  input  logic [PC_W-1:0]  res_target_i,
  // current contents at the resolved index
  output logic [IDX_W-1:0] look_idx_o,
  input  logic             look_vld_i,
  input  logic [PC_W-1:0]  look_pc_i,
  // outcome
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o,
  output ftb_act_e         act_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [PC_W-1:0]  wr_pc_o,
  output logic [PC_W-1:0]  wr_tgt_o
);
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] true_next;
  logic            still_ours;

  assign seq_pc     = res_pc_i + PC_W'(INSTR_BYTES);
  assign true_next  = res_taken_i ? res_target_i : seq_pc;
  assign look_idx_o = res_pc_i[LSB +: IDX_W];
  assign still_ours = look_vld_i && (look_pc_i == res_pc_i);

  assign redirect_o    = res_valid_i && (true_next != res_pred_pc_i);
  assign redirect_pc_o = true_next;

  always_comb begin
    act_o = ACT_NONE;
    if (res_valid_i) begin
      if (res_taken_i && (!res_hit_i || res_target_i != res_pred_pc_i)) begin
        act_o = ACT_WRITE;
      end else if (!res_taken_i && res_hit_i && still_ours) begin
        act_o = ACT_DROP;
      end
    end
  end

  assign wr_idx_o = look_idx_o;
  assign wr_pc_o  = res_pc_i;
  assign wr_tgt_o = res_target_i;

  // R9
  no_res_no_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |-> !redirect_o && act_o == ACT_NONE);

  // R6
  good_taken_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_hit_i && res_taken_i && res_pred_pc_i == res_target_i
    |-> !redirect_o && act_o == ACT_NONE);

  // R7
  plain_miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && !res_hit_i && !res_taken_i && res_pred_pc_i == seq_pc
    |-> !redirect_o && act_o == ACT_NONE);
endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer
  import ftb_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned ENTRIES = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            hit_o,
  output logic [PC_W-1:0] pred_pc_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_hit_i,
  input  logic [PC_W-1:0] res_pred_pc_i,
  input  logic            res_taken_i,
  input  logic [PC_W-1:0] res_target_i,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned LSB   = $clog2(INSTR_BYTES);

  logic [IDX_W-1:0] f_idx, r_idx, w_idx;
  logic             f_vld, r_vld;
  logic [PC_W-1:0]  f_pc, f_tgt, r_pc, w_pc, w_tgt;
  ftb_act_e         act;

  assign f_idx = fetch_pc_i[LSB +: IDX_W];

  ftb_store #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_store (
    .clk_i, .rst_ni,
    .rd_a_idx_i (f_idx), .rd_a_vld_o (f_vld), .rd_a_pc_o (f_pc), .rd_a_tgt_o (f_tgt),
    .rd_b_idx_i (r_idx), .rd_b_vld_o (r_vld), .rd_b_pc_o (r_pc),
    .act_i (act), .wr_idx_i (w_idx), .wr_pc_i (w_pc), .wr_tgt_i (w_tgt)
  );

  ftb_resolve #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_resolve (
    .clk_i, .rst_ni,
    .res_valid_i, .res_pc_i, .res_hit_i, .res_pred_pc_i, .res_taken_i, .res_target_i,
    .look_idx_o (r_idx), .look_vld_i (r_vld), .look_pc_i (r_pc),
    .redirect_o, .redirect_pc_o,
    .act_o (act), .wr_idx_o (w_idx), .wr_pc_o (w_pc), .wr_tgt_o (w_tgt)
  );

  // full-address compare: a hit redirects fetch before decode sees the word
  assign hit_o     = f_vld && (f_pc == fetch_pc_i);
  assign pred_pc_o = hit_o ? f_tgt : fetch_pc_i + PC_W'(INSTR_BYTES);

  // R4
  alloc_then_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_taken_i && !res_hit_i ##1 fetch_pc_i == $past(res_pc_i)
    |-> hit_o && pred_pc_o == $past(res_target_i));
endmodule

// File: tb/tb_fetch_target_buffer.sv
module tb_fetch_target_buffer;
  localparam int unsigned PC_W = 32;
  localparam int unsigned N    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [PC_W-1:0] fetch_pc = '0, pred_pc, res_pc = '0, res_pred = '0, res_tgt = '0, redir_pc;
  logic hit, redir, res_v = 1'b0, res_hit = 1'b0, res_tk = 1'b0;

  fetch_target_buffer #(.PC_W(PC_W), .ENTRIES(N)) dut (
    .clk_i (clk), .rst_ni (rst_n), .fetch_pc_i (fetch_pc), .hit_o (hit), .pred_pc_o (pred_pc),
    .res_valid_i (res_v), .res_pc_i (res_pc), .res_hit_i (res_hit), .res_pred_pc_i (res_pred),
    .res_taken_i (res_tk), .res_target_i (res_tgt), .redirect_o (redir), .redirect_pc_o (redir_pc)
  );

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  // reference: address -> target for live branches, by slot
  bit          m_live [int];
  longint      m_addr [int];
  longint      m_tgt  [int];

  function automatic int slot(longint a);
    return int'((a / 4) % N);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // inputs already driven at negedge; check, then advance model at posedge
  task automatic step(string req);
    longint fp, e_pred, nxt;
    bit e_hit, e_red;
    int s, rs;
    #1;
    fp = longint'(fetch_pc);
    s = slot(fp);
    e_hit = m_live.exists(s) && m_live[s] && m_addr[s] == fp;
    e_pred = e_hit ? m_tgt[s] : (fp + 4) & 64'hFFFF_FFFF;
    nxt = res_tk ? longint'(res_tgt) : (longint'(res_pc) + 4) & 64'hFFFF_FFFF;
    e_red = res_v && nxt != longint'(res_pred);
    chk(req, "hit", longint'(hit), longint'(e_hit));
    chk(req, "pred_pc", longint'(pred_pc), e_pred);
    chk(req, "redirect", longint'(redir), longint'(e_red));
    if (e_red) chk(req, "redirect_pc", longint'(redir_pc), nxt);
    @(posedge clk);
    rs = slot(longint'(res_pc));
    if (res_v) begin
      if (res_tk && (!res_hit || res_tgt != res_pred)) begin
        m_live[rs] = 1; m_addr[rs] = longint'(res_pc); m_tgt[rs] = longint'(res_tgt);
      end else if (!res_tk && res_hit && m_live.exists(rs) && m_live[rs]
                   && m_addr[rs] == longint'(res_pc)) begin
        m_live[rs] = 0;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(logic [PC_W-1:0] pc);
    fetch_pc = pc; res_v = 0; res_hit = 0; res_tk = 0;
  endtask

  task automatic resolve(logic [PC_W-1:0] pc, logic h, logic [PC_W-1:0] pr, logic tk, logic [PC_W-1:0] tg);
    res_v = 1; res_pc = pc; res_hit = h; res_pred = pr; res_tk = tk; res_tgt = tg;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
  always @(posedge clk) cycles++;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, before and after release
    idle(32'h100); step("R1");
    rst_n = 1'b1; @(negedge clk);
    idle(32'h100); step("R1");
    idle(32'h3C); step("R1");
    // R4 miss with taken branch allocates and redirects
    idle(32'h104); resolve(32'h100, 0, 32'h104, 1, 32'h400); step("R4");
    idle(32'h100); step("R3");
    // R2 alias at same index, different upper bits
    idle(32'h140); step("R2");
    idle(32'h1100); step("R2");
    // R6 correct taken hit
    idle(32'h400); resolve(32'h100, 1, 32'h400, 1, 32'h400); step("R6");
    idle(32'h100); step("R6");
    // R8 wrong target retarget
    idle(32'h400); resolve(32'h100, 1, 32'h400, 1, 32'h480); step("R8");
    idle(32'h100); step("R8");
    // R5 hit not taken: redirect sequential, drop entry
    idle(32'h480); resolve(32'h100, 1, 32'h480, 0, 32'h0); step("R5");
    idle(32'h100); step("R5");
    // R7 plain instruction miss
    idle(32'h204); resolve(32'h200, 0, 32'h204, 0, 32'h0); step("R7");
    idle(32'h200); step("R7");
    // R9 resolution fields with valid low
    idle(32'h300); res_pc = 32'h300; res_tk = 1; res_tgt = 32'h900; res_pred = 32'h304; step("R9");
    idle(32'h300); step("R9");
    // R10 replacement at shared index
    idle(32'h0); resolve(32'h100, 0, 32'h104, 1, 32'h400); step("R10");
    idle(32'h0); resolve(32'h140, 0, 32'h144, 1, 32'h800); step("R10");
    idle(32'h100); step("R10");
    idle(32'h140); step("R10");
    // R11 stale not-taken for overwritten branch keeps the newer one
    idle(32'h0); resolve(32'h100, 1, 32'h400, 0, 32'h0); step("R11");
    idle(32'h140); step("R11");
    // R3 fill every index and read back
    for (int i = 0; i < N; i++) begin
      idle(32'h0); resolve(32'h2000 + 4 * i, 0, 32'h2004 + 4 * i, 1, 32'h8000 + 16 * i); step("R4");
    end
    for (int i = 0; i < N; i++) begin
      idle(32'h2000 + 4 * i); step("R3");
    end
    // mixed traffic while looking up other addresses
    for (int i = 0; i < 3 * N; i++) begin
      logic [PC_W-1:0] a;
      a = 32'h2000 + 4 * (i % N) + ((i / N) == 1 ? 32'h40 : 32'h0);
      idle(32'h2000 + 4 * ((i + 5) % N));
      resolve(a, i[0], i[0] ? 32'h8000 + 16 * (i % N) : a + 4, i[1], 32'hA000 + 8 * i);
      step("R5");
    end
    idle(32'h0); step("R9");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule